// File: doc/BRIEF.md
# Dual-Vector Peripheral Interrupt Generator

This block raises bus interrupt requests for a communications controller that answers on two vectors. The first vector (A) tells the host that the controller can take a new input command. The second vector (B) tells the host that a completion or status report is waiting. Both come from one programmable base: A is the base itself and B is the base plus four. The host reaches the block through a four-byte CSR window. It can read a byte, write it, set bits in it or clear bits in it.

The host sets a request-input bit to ask for a command slot. The controller side reports through two pins. The first is a level that says the controller is idle and able to take a command. The second is a one-cycle strobe that says an output is ready. The block turns these into two ready status bits and arms one interrupt per bit. It holds a request line towards the bus. When a grant arrives, it returns exactly one vector on the next cycle. If both interrupts are pending, A is served first.

A ready bit can only be cleared by the host, and clearing it withdraws the interrupt it armed. After the host clears ready-in, ready-in stays low until the controller has dropped its idle level and raised it again. A queued command therefore cannot retrigger at once.

Top module: `dvec_irq_ctrl`

## Requirements
- R1: After reset, all four CSR bytes read 0, `irq_req` is low and `irq_vec_valid` is low.
- R2: `csr_op` encodes 0 as read, 1 as write, 2 as bit-set and 3 as bit-clear. Each op acts on the byte selected by `csr_addr` when `csr_req` is high, and `csr_rdata` always shows that byte. Byte 0 holds request-input at bit 0 and the master interrupt enable at bit 7; its other bits read 0. Byte 2 holds base bits 7:0, with bits 1:0 always reading 0. Byte 3 holds base bits above 7, which read 0 at the default 8-bit width.
- R3: In byte 1, ready-in is bit 4 (octal 20) and ready-out is bit 7 (octal 200). The host can only clear these bits: a write clears each bit written as 0, a bit-clear clears each bit given as 1, and a bit-set has no effect. Host access never sets a ready bit.
- R4: Ready-in becomes 1 on the cycle after a cycle in which request-input is 1, `ctl_idle` is 1 and ready-in is 0, unless the hold of R5 is active.
- R5: Once the host clears ready-in, ready-in cannot return until `ctl_idle` has been sampled low on some later cycle and then high again.
- R6: A `ctl_out_strobe` pulse sets ready-out on the next cycle. If ready-out was 0, the pulse also arms the B interrupt.
- R7: `irq_req` is high exactly when the master enable is 1 and at least one armed interrupt still has its ready bit set. Clearing the enable drops `irq_req` but keeps both ready bits.
- R8: A cycle with `irq_gnt` high while `irq_req` is high causes `irq_vec_valid` to pulse on the next cycle. `irq_vec` then carries the base for A, or the base plus 4 for B. A is chosen whenever both are pending.
- R9: A grant disarms only the interrupt it served. That interrupt is not requested again until its ready bit goes from 0 to 1 again.
- R10: An interrupt whose ready bit the host clears before it is granted is never delivered. A grant while `irq_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR access strobe for this cycle |
| csr_op | input | 2 | 0 read, 1 write, 2 bit-set, 3 bit-clear |
| csr_addr | input | 2 | CSR byte select |
| csr_wdata | input | 8 | Write data or bit mask |
| csr_rdata | output | 8 | Contents of the selected byte |
| ctl_idle | input | 1 | Controller can accept a command (level) |
| ctl_out_strobe | input | 1 | Controller has an output ready (one-cycle pulse) |
| irq_gnt | input | 1 | Bus grant for the pending request |
| irq_req | output | 1 | Interrupt request to the bus |
| irq_vec | output | 8 | Vector returned for the grant |
| irq_vec_valid | output | 1 | One-cycle pulse marking `irq_vec` |

## Verification
A wrong arm flag or hold flag shows at the ports within one cycle. It appears as `irq_req` high with no live ready bit behind it, or as ready-in reappearing in byte 1 on the cycle right after the host cleared it. A wrong priority or stride in the vector path shows on the `irq_vec_valid` cycle that follows the first tied grant. The bench compares `irq_req`, the vector outputs and the addressed CSR byte on every cycle, so a state error surfaces on the cycle it is made.

// File: rtl/dvi_pkg.sv
package dvi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_SET = 2'd2,
    OP_CLR = 2'd3
  } csr_op_e;

  // positions decoded by host software
  localparam int RQI_POS  = 0;
  localparam int IE_POS   = 7;
  localparam int RDYI_POS = 4;
  localparam int RDYO_POS = 7;

  localparam logic [BYTE_W-1:0] CTL_MASK = 8'h81;

  function automatic logic [BYTE_W-1:0] byte_op(input csr_op_e op,
      input logic [BYTE_W-1:0] cur, input logic [BYTE_W-1:0] wd,
      input logic [BYTE_W-1:0] mask);
    case (op)
      OP_WR:   byte_op = (wd & mask) | (cur & ~mask);
      OP_SET:  byte_op = cur | (wd & mask);
      OP_CLR:  byte_op = cur & ~(wd & mask);
      default: byte_op = cur;
    endcase
  endfunction
endpackage

// File: rtl/dvi_csr_regs.sv
module dvi_csr_regs
  import dvi_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int ALIGN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic [1:0]       csr_op,
  input  logic [1:0]       csr_addr,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic             ctl_idle,
  input  logic             ctl_out_strobe,
  output logic             rqi,
  output logic             ie,
  output logic             rdyi,
  output logic             rdyo,
  output logic [VEC_W-1:0] base,
  output logic             set_a,
  output logic             set_b
);
  localparam logic [31:0] MASK32 = ((32'd1 << VEC_W) - 32'd1) & ~((32'd1 << ALIGN) - 32'd1);
  localparam logic [15:0] BASE_MASK = MASK32[15:0];

  csr_op_e op;
  logic    wr_en;
  logic [7:0]  ctl_q, ctl_d, sts_q, sts_host, sts_d;
  logic [15:0] base16, base16_d;
  logic        hold_q, hold_d, host_clr_i;

  assign op     = csr_op_e'(csr_op);
  assign wr_en  = csr_req && (op != OP_RD);
  assign base16 = 16'(base);

  assign rqi  = ctl_q[RQI_POS];
  assign ie   = ctl_q[IE_POS];
  assign rdyi = sts_q[RDYI_POS];
  assign rdyo = sts_q[RDYO_POS];

  assign set_a = rqi && ctl_idle && !rdyi && !hold_q;
  assign set_b = ctl_out_strobe && !rdyo;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && csr_addr == 2'd0) ctl_d = byte_op(op, ctl_q, csr_wdata, CTL_MASK);

    sts_host = sts_q;
    if (wr_en && csr_addr == 2'd1) begin
      case (op)
        OP_WR:   sts_host = sts_q & csr_wdata;
        OP_CLR:  sts_host = sts_q & ~csr_wdata;
        default: sts_host = sts_q;
      endcase
    end
    host_clr_i = rdyi && !sts_host[RDYI_POS];
    sts_d = sts_host;
    if (set_a)          sts_d[RDYI_POS] = 1'b1;
    if (ctl_out_strobe) sts_d[RDYO_POS] = 1'b1;

    if (host_clr_i)     hold_d = 1'b1;
    else if (!ctl_idle) hold_d = 1'b0;
    else                hold_d = hold_q;

    base16_d = base16;
    if (wr_en && csr_addr == 2'd2)
      base16_d[7:0] = byte_op(op, base16[7:0], csr_wdata, BASE_MASK[7:0]);
    if (wr_en && csr_addr == 2'd3)
      base16_d[15:8] = byte_op(op, base16[15:8], csr_wdata, BASE_MASK[15:8]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      sts_q  <= '0;
      hold_q <= 1'b0;
      base   <= '0;
    end else begin
      ctl_q  <= ctl_d;
      sts_q  <= sts_d;
      hold_q <= hold_d;
      base   <= base16_d[VEC_W-1:0];
    end
  end

  always_comb begin
    case (csr_addr)
      2'd0:    csr_rdata = ctl_q;
      2'd1:    csr_rdata = sts_q;
      2'd2:    csr_rdata = base16[7:0];
      default: csr_rdata = base16[15:8];
    endcase
  end
endmodule

// File: rtl/dvi_irq_arb.sv
module dvi_irq_arb #(
  parameter int VEC_W  = 8,
  parameter int STRIDE = 4,
  parameter int NSRC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ie,
  input  logic [NSRC-1:0]  rdy,
  input  logic [NSRC-1:0]  set_ev,
  input  logic [VEC_W-1:0] base,
  input  logic             irq_gnt,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_vec_valid
);
  logic [NSRC-1:0] arm, live, win;
  logic            accept;

  assign live    = arm & rdy;
  assign irq_req = ie && (|live);
  assign accept  = irq_gnt && irq_req;
  // lowest index wins: A before B
  assign win     = live & (~live + NSRC'(1));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic arm_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                  arm_q <= 1'b0;
      else if (set_ev[i])          arm_q <= 1'b1;
      else if (accept && win[i])   arm_q <= 1'b0;
    end
    assign arm[i] = arm_q;
  end

  logic [VEC_W-1:0] pick;
  always_comb begin
    pick = base;
    for (int i = NSRC - 1; i >= 0; i--)
      if (win[i]) pick = base + VEC_W'(STRIDE * i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_vec_valid <= 1'b0;
      irq_vec       <= '0;
    end else begin
      irq_vec_valid <= accept;
      if (accept) irq_vec <= pick;
    end
  end
endmodule

// File: rtl/dvec_irq_ctrl.sv
module dvec_irq_ctrl #(
  parameter int VEC_W  = 8,
  parameter int ALIGN  = 2,
  parameter int STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic [1:0]       csr_op,
  input  logic [1:0]       csr_addr,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic             ctl_idle,
  input  logic             ctl_out_strobe,
  input  logic             irq_gnt,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_vec_valid
);
  logic             rqi, ie, rdyi, rdyo, set_a, set_b;
  logic [VEC_W-1:0] base;

  dvi_csr_regs #(.VEC_W(VEC_W), .ALIGN(ALIGN)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ctl_idle(ctl_idle), .ctl_out_strobe(ctl_out_strobe),
    .rqi(rqi), .ie(ie), .rdyi(rdyi), .rdyo(rdyo), .base(base),
    .set_a(set_a), .set_b(set_b)
  );

  dvi_irq_arb #(.VEC_W(VEC_W), .STRIDE(STRIDE), .NSRC(2)) u_arb (
    .clk(clk), .rst_n(rst_n), .ie(ie), .rdy({rdyo, rdyi}),
    .set_ev({set_b, set_a}), .base(base), .irq_gnt(irq_gnt),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_vec_valid(irq_vec_valid)
  );
endmodule

// File: rtl/dvec_irq_chk.sv
module dvec_irq_chk #(
  parameter int VEC_W  = 8,
  parameter int STRIDE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_idle,
  input logic             ctl_out_strobe,
  input logic             irq_gnt,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_vec_valid,
  input logic             rqi,
  input logic             ie,
  input logic             rdyi,
  input logic             rdyo,
  input logic [VEC_W-1:0] base
);
  // R7
  req_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ie && (rdyi || rdyo)));

  // R4
  rdyi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdyi) |-> $past(rqi && ctl_idle));

  // R5
  rdyi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdyi) |=> !rdyi);

  // R6
  rdyo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdyo) |-> $past(ctl_out_strobe));

  // R8
  vec_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec_valid |-> $past(irq_gnt && irq_req));

  // R8
  vec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec_valid |-> (irq_vec == $past(base) || irq_vec == $past(base) + VEC_W'(STRIDE)));
endmodule

bind dvec_irq_ctrl dvec_irq_chk #(.VEC_W(VEC_W), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_idle(ctl_idle), .ctl_out_strobe(ctl_out_strobe),
  .irq_gnt(irq_gnt), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_vec_valid(irq_vec_valid), .rqi(rqi), .ie(ie), .rdyi(rdyi),
  .rdyo(rdyo), .base(base)
);

// File: tb/dvec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dvec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_req = 1'b0;
  logic [1:0] csr_op = 2'd0;
  logic [1:0] csr_addr = 2'd0;
  logic [7:0] csr_wdata = 8'd0;
  logic [7:0] csr_rdata;
  logic       ctl_idle = 1'b0;
  logic       ctl_out_strobe = 1'b0;
  logic       irq_gnt = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       irq_vec_valid;

  always #4 clk = ~clk;

  dvec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ctl_idle(ctl_idle), .ctl_out_strobe(ctl_out_strobe), .irq_gnt(irq_gnt),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_vec_valid(irq_vec_valid)
  );

  int n_chk = 0;
  int n_bad = 0;

  // expected state, derived from the requirements
  logic [7:0] m_ctl = 0, m_sts = 0, m_base = 0, m_vec = 0;
  logic       m_hold = 0, m_vv = 0;
  logic [1:0] m_arm = 0;
  logic       idle_lvl = 1'b0;

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl;
      2'd1: return m_sts;
      2'd2: return m_base;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_req();
    return m_ctl[7] && ((m_arm[0] && m_sts[4]) || (m_arm[1] && m_sts[7]));
  endfunction

  function automatic logic [7:0] op_apply(input logic [1:0] op, input logic [7:0] cur,
                                          input logic [7:0] wd, input logic [7:0] mask);
    case (op)
      2'd1: return (wd & mask) | (cur & ~mask);
      2'd2: return cur | (wd & mask);
      2'd3: return cur & ~(wd & mask);
      default: return cur;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tg, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tg, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic req, input logic [1:0] op, input logic [1:0] addr,
                     input logic [7:0] wd, input logic strobe, input logic gnt, input string tg);
    logic [7:0] n_ctl, n_sts, n_base, n_vec;
    logic       seti, seto, la, lb, acc, n_hold, n_vv;
    logic [1:0] n_arm;
    csr_req = req; csr_op = op; csr_addr = addr; csr_wdata = wd;
    ctl_idle = idle_lvl; ctl_out_strobe = strobe; irq_gnt = gnt;
    n_ctl = m_ctl; n_sts = m_sts; n_base = m_base;
    if (req && op != 2'd0) begin
      if (addr == 2'd0) n_ctl = op_apply(op, m_ctl, wd, 8'h81);
      if (addr == 2'd1) n_sts = (op == 2'd1) ? (m_sts & wd) : (op == 2'd3) ? (m_sts & ~wd) : m_sts;
      if (addr == 2'd2) n_base = op_apply(op, m_base, wd, 8'hFC);
    end
    n_hold = (m_sts[4] && !n_sts[4]) ? 1'b1 : (!idle_lvl ? 1'b0 : m_hold);
    seti = m_ctl[0] && idle_lvl && !m_sts[4] && !m_hold;
    seto = strobe && !m_sts[7];
    if (seti) n_sts[4] = 1'b1;
    if (strobe) n_sts[7] = 1'b1;
    la = m_arm[0] && m_sts[4];
    lb = m_arm[1] && m_sts[7];
    acc = gnt && exp_req();
    n_vv = acc;
    n_vec = acc ? (la ? m_base : m_base + 8'd4) : m_vec;
    n_arm[0] = seti ? 1'b1 : ((acc && la) ? 1'b0 : m_arm[0]);
    n_arm[1] = seto ? 1'b1 : ((acc && !la) ? 1'b0 : m_arm[1]);
    @(posedge clk);
    #1;
    m_ctl = n_ctl; m_sts = n_sts; m_base = n_base; m_hold = n_hold;
    m_vv = n_vv; m_vec = n_vec; m_arm = n_arm;
    chk({7'd0, irq_req}, {7'd0, exp_req()}, (tg == "") ? "R7" : tg, "irq_req");
    chk({7'd0, irq_vec_valid}, {7'd0, m_vv}, (tg == "") ? "R8" : tg, "irq_vec_valid");
    if (m_vv) chk(irq_vec, m_vec, (tg == "") ? "R8" : tg, "irq_vec");
    chk(csr_rdata, exp_rd(addr), (tg == "") ? "R2" : tg, "csr_rdata");
  endtask

  task automatic rd(input logic [1:0] a, input string tg);
    cyc(1'b1, 2'd0, a, 8'h00, 1'b0, 1'b0, tg);
  endtask

  task automatic acc_op(input logic [1:0] op, input logic [1:0] a, input logic [7:0] wd, input string tg);
    cyc(1'b1, op, a, wd, 1'b0, 1'b0, tg);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");
    // R2 byte ops
    acc_op(2'd1, 2'd2, 8'h47, "R2");    // base -> 0x44
    acc_op(2'd3, 2'd2, 8'h04, "R2");    // 0x40
    acc_op(2'd2, 2'd2, 8'h13, "R2");    // 0x50
    acc_op(2'd1, 2'd3, 8'hFF, "R2");
    acc_op(2'd1, 2'd0, 8'h7E, "R2");    // unused bits stay 0
    // R6 ready-out from strobe, R3 host cannot set
    idle_lvl = 1'b1;
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b1, 1'b0, "R6");
    acc_op(2'd1, 2'd1, 8'hFF, "R3");
    acc_op(2'd2, 2'd1, 8'h10, "R3");
    rd(2'd1, "R3");
    // R4 request-input raises ready-in
    acc_op(2'd2, 2'd0, 8'h01, "R4");
    rd(2'd1, "R4");
    // R7 enable gates request, keeps ready bits
    acc_op(2'd2, 2'd0, 8'h80, "R7");
    acc_op(2'd3, 2'd0, 8'h80, "R7");
    rd(2'd1, "R7");
    acc_op(2'd2, 2'd0, 8'h80, "R7");
    // R8 tie -> A at base, then R9 B at base+4, then R10 idle grant
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b0, 1'b1, "R8");
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b0, 1'b1, "R9");
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b0, 1'b1, "R10");
    rd(2'd1, "R9");
    // R5 hold after host clears ready-in
    acc_op(2'd3, 2'd1, 8'h10, "R5");
    for (int i = 0; i < 4; i++) rd(2'd1, "R5");
    idle_lvl = 1'b0;
    rd(2'd1, "R5");
    idle_lvl = 1'b1;
    rd(2'd1, "R5");
    rd(2'd1, "R5");
    // R10 ready-out withdrawn before grant
    acc_op(2'd1, 2'd1, 8'h00, "R10");
    acc_op(2'd3, 2'd0, 8'h01, "R10");
    acc_op(2'd1, 2'd1, 8'h00, "R10");
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b1, 1'b0, "R10");
    acc_op(2'd3, 2'd1, 8'h80, "R10");
    cyc(1'b0, 2'd0, 2'd1, 8'h00, 1'b0, 1'b1, "R10");
    rd(2'd1, "R10");
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] op, a;
      logic [7:0] wd;
      if (($urandom % 5) == 0) idle_lvl = ~idle_lvl;
      op = 2'($urandom % 4);
      a  = 2'($urandom % 4);
      wd = 8'($urandom);
      if (a == 2'd0 && op == 2'd3 && ($urandom % 2) == 0) wd[7] = 1'b0;
      cyc(($urandom % 3) == 0, op, a, wd, ($urandom % 8) == 0, ($urandom % 3) == 0, "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule